// File: doc/BRIEF.md
# Periodic Sync Phase Aligner

This block keeps a free-running clock-generation phase counter lined up with an external periodic reference pulse, so that several converters fed with the same reference can update their outputs on the same sample-clock edge. The reference input is captured on a selectable edge of the fast sample clock. It then passes through a synchronizer and a rising-edge detector, which turn each reference pulse into a single-cycle event.

At every event the block reads the counter and turns that reading into a signed phase error. The error is the distance from phase zero, folded into the range of half a period either side of zero. Errors are summed over a window of 2^n events and divided by 2^n with an arithmetic shift. When the windowed average lies more than one count from zero, the counter is realigned to the current event, the window restarts and lock drops. A window that closes within one count raises lock.

A small byte-wide register interface carries the control byte, an interrupt-enable byte and a status byte. The status byte holds the live lock bit and a sticky loss flag. The loss flag is set when a locked block has to realign, and software clears it with a write.

Top module: `sync_align_ctrl`

## Requirements
- R1: While reset is asserted, `phase_o` is 0, `irq_o` is 0, and reads of addresses 0x10, 0x11 and 0x12 return 0x00.
- R2: The control byte lives at address 0x10 and reads back as it was written. Bit 7 enables alignment, bit 3 selects the capture edge (1 = rising, 0 = falling) and bits [2:0] hold n, which sets a window depth of 2^n events (1 to 128).
- R3: The reference input is captured on the selected edge and then passes through two synchronizer flops. Each low-to-high transition yields exactly one single-cycle event, and alignment works with either edge selected.
- R4: `phase_o` counts 0, 1, …, PERIOD-1 and wraps to 0, advancing by one every cycle unless a realignment occurs.
- R5: A window whose averaged error lies in {-1, 0, +1} sets the lock bit. A persistent offset of one count in either direction therefore leaves the block locked and does not set the loss flag.
- R6: A window whose averaged error lies outside {-1, 0, +1} realigns the counter: in the next cycle `phase_o` is 1 and lock is clear. The window restarts empty, and the block relocks after the next good window.
- R7: Averaging filters jitter. A single pulse displaced by 3 counts inside a window of 8 events leaves lock and the loss flag unchanged, while the same pulse with a window of 1 event forces a realignment.
- R8: Status bit 7 (lost) sets when a realignment happens while locked and stays set until a write to 0x12 with bit 7 = 1. A write with bit 7 = 0 leaves it unchanged.
- R9: Reading 0x12 returns the lock bit in bit 6 and the loss flag in bit 7, with bits [5:0] zero. Addresses other than 0x10, 0x11 and 0x12 read as 0x00.
- R10: The interrupt-enable byte lives at 0x11 and reads back as written. `irq_o` is high while (bit 6 set and locked) or (bit 7 set and lost).
- R11: With the enable bit clear, events are ignored and lock is held at 0, while the loss flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | External periodic reference pulse |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request, level |
| phase_o | output | PHASE_W | Current clock-generation phase |

## Verification
A corrupted phase counter shows up on `phase_o` in the very next cycle as a skipped or repeated count. It is also visible within one averaging window as a spurious realignment, which sets the loss flag. A wrong accumulator or window counter shows up only when the window closes, so the bench waits several full windows before each check. Stuck lock or loss state is visible at once on a read of 0x12 and on `irq_o`.

// File: rtl/sync_align_pkg.sv
package sync_align_pkg;

  localparam logic [7:0] ADDR_CTRL  = 8'h10;
  localparam logic [7:0] ADDR_IRQEN = 8'h11;
  localparam logic [7:0] ADDR_STAT  = 8'h12;

  localparam int STAT_LOCK_BIT = 6;
  localparam int STAT_LOST_BIT = 7;

  typedef struct packed {
    logic       enable;
    logic [2:0] spare;
    logic       rise_sel;
    logic [2:0] depth_log2;
  } align_ctrl_t;

endpackage

// File: rtl/sa_edge_sampler.sv
module sa_edge_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic rise_sel,
  output logic evt_o
);

  logic                   rise_q;
  logic                   fall_q;
  logic                   pick;
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_n;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= sync_in;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= sync_in;
  end

  always_comb begin
    pick    = rise_sel ? rise_q : fall_q;
    chain_n = {chain_q[SYNC_STAGES-2:0], pick};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      prev_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign evt_o = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/sa_phase_track.sv
module sa_phase_track #(
  parameter int PERIOD  = 16,
  parameter int PHASE_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2:0]         depth_log2,
  input  logic               evt,
  output logic [PHASE_W-1:0] phase_o,
  output logic               locked_o,
  output logic               resync_o,
  output logic               lose_o
);

  localparam int ERR_W = PHASE_W + 2;
  localparam int ACC_W = ERR_W + 7;
  localparam int HALF  = PERIOD / 2;
  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(PERIOD - 1);
  localparam logic signed [ACC_W-1:0] POS1 = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] NEG1 = -ACC_W'(1);

  logic [PHASE_W-1:0]      phase_q, phase_n;
  logic signed [ACC_W-1:0] acc_q, acc_n;
  logic [7:0]              cnt_q, cnt_n;
  logic                    lock_q, lock_n;

  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] avg;
  logic [7:0]              lim;
  logic                    last_evt;
  logic                    far;
  logic                    resync;

  always_comb begin
    if (phase_q >= PHASE_W'(HALF))
      err = $signed({2'b00, phase_q}) - $signed(ERR_W'(PERIOD));
    else
      err = $signed({2'b00, phase_q});
    sum      = acc_q + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    avg      = sum >>> depth_log2;
    lim      = 8'((9'd1 << depth_log2) - 9'd1);
    last_evt = cnt_q >= lim;
    far      = (avg > POS1) || (avg < NEG1);
    resync   = en && evt && last_evt && far;
  end

  always_comb begin
    phase_n = (phase_q == LAST_PH) ? '0 : phase_q + PHASE_W'(1);
    acc_n   = acc_q;
    cnt_n   = cnt_q;
    lock_n  = lock_q;
    if (resync) phase_n = PHASE_W'(1);
    if (!en) begin
      acc_n  = '0;
      cnt_n  = '0;
      lock_n = 1'b0;
    end else if (evt) begin
      if (last_evt) begin
        acc_n  = '0;
        cnt_n  = '0;
        lock_n = !far;
      end else begin
        acc_n = sum;
        cnt_n = cnt_q + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      acc_q   <= acc_n;
      cnt_q   <= cnt_n;
      lock_q  <= lock_n;
    end
  end

  assign phase_o  = phase_q;
  assign locked_o = lock_q;
  assign resync_o = resync;
  assign lose_o   = resync && lock_q;

endmodule

// File: rtl/sa_regs.sv
module sa_regs
  import sync_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       locked,
  input  logic       lose_evt,
  output logic [7:0] rdata,
  output logic       en_o,
  output logic       rise_o,
  output logic [2:0] depth_o,
  output logic       lost_o,
  output logic       irq_o
);

  align_ctrl_t ctrl_q, ctrl_n;
  logic [7:0]  irqen_q, irqen_n;
  logic        lost_q, lost_n;
  logic        ctrl_we, irq_we, clr_lost;

  always_comb begin
    ctrl_we  = wr && (addr == ADDR_CTRL);
    irq_we   = wr && (addr == ADDR_IRQEN);
    clr_lost = wr && (addr == ADDR_STAT) && wdata[STAT_LOST_BIT];
    ctrl_n   = ctrl_we ? align_ctrl_t'(wdata) : ctrl_q;
    irqen_n  = irq_we ? wdata : irqen_q;
    if (lose_evt)      lost_n = 1'b1;
    else if (clr_lost) lost_n = 1'b0;
    else               lost_n = lost_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      irqen_q <= '0;
      lost_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      irqen_q <= irqen_n;
      lost_q  <= lost_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL:  rdata = ctrl_q;
      ADDR_IRQEN: rdata = irqen_q;
      ADDR_STAT: begin
        rdata[STAT_LOCK_BIT] = locked;
        rdata[STAT_LOST_BIT] = lost_q;
      end
      default:    rdata = '0;
    endcase
  end

  assign en_o    = ctrl_q.enable;
  assign rise_o  = ctrl_q.rise_sel;
  assign depth_o = ctrl_q.depth_log2;
  assign lost_o  = lost_q;
  assign irq_o   = (irqen_q[STAT_LOCK_BIT] & locked) | (irqen_q[STAT_LOST_BIT] & lost_q);

endmodule

// File: rtl/sync_align_ctrl.sv
module sync_align_ctrl #(
  parameter int PERIOD      = 16,
  parameter int PHASE_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               reg_wr,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_o,
  output logic [PHASE_W-1:0] phase_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       en;
  logic       rise_sel;
  logic [2:0] depth_log2;
  logic       sync_evt;
  logic       locked;
  logic       lost;
  logic       resync;
  logic       lose_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  sa_edge_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sync_in  (sync_in),
    .rise_sel (rise_sel),
    .evt_o    (sync_evt)
  );

  sa_phase_track #(.PERIOD(PERIOD), .PHASE_W(PHASE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (en),
    .depth_log2 (depth_log2),
    .evt        (sync_evt),
    .phase_o    (phase_o),
    .locked_o   (locked),
    .resync_o   (resync),
    .lose_o     (lose_evt)
  );

  sa_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .locked   (locked),
    .lose_evt (lose_evt),
    .rdata    (reg_rdata),
    .en_o     (en),
    .rise_o   (rise_sel),
    .depth_o  (depth_log2),
    .lost_o   (lost),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/sync_align_chk.sv
module sync_align_chk
  import sync_align_pkg::*;
#(
  parameter int PERIOD  = 16,
  parameter int PHASE_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt,
  input logic [PHASE_W-1:0] phase,
  input logic               resync,
  input logic               locked,
  input logic               lost,
  input logic               lose_evt,
  input logic               en,
  input logic               reg_wr,
  input logic [7:0]         reg_addr,
  input logic               wr_clr_bit,
  input logic [7:0]         reg_rdata
);

  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(PERIOD - 1);

  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST_PH && !resync) |=> phase == '0);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != LAST_PH && !resync) |=> phase == $past(phase) + PHASE_W'(1));

  a_r6_realign: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (phase == PHASE_W'(1) && !locked));

  a_r8_lost_set: assert property (@(posedge clk) disable iff (!rst_n)
    lose_evt |=> lost);

  a_r8_lost_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !(reg_wr && reg_addr == ADDR_STAT && wr_clr_bit)) |=> lost);

  a_r9_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_STAT) |-> (reg_rdata[5:0] == 6'd0 &&
                                 reg_rdata[STAT_LOCK_BIT] == locked &&
                                 reg_rdata[STAT_LOST_BIT] == lost));

  a_r11_idle_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);

endmodule

bind sync_align_ctrl sync_align_chk #(.PERIOD(PERIOD), .PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .evt        (sync_evt),
  .phase      (phase_o),
  .resync     (resync),
  .locked     (locked),
  .lost       (lost),
  .lose_evt   (lose_evt),
  .en         (en),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wr_clr_bit (reg_wdata[7]),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_sync_align_ctrl.sv
`timescale 1ns/1ps
module test_sync_align_ctrl;

  localparam int PERIOD  = 16;
  localparam int PHASE_W = 7;

  typedef struct packed {
    logic [2:0]        dep;
    logic              rise;
    logic signed [7:0] shift;
    logic              once;
    logic              exp_lost;
  } row_t;

  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{3'd0, 1'b1,  8'sd3, 1'b0, 1'b1},
    '{3'd0, 1'b1,  8'sd1, 1'b0, 1'b0},
    '{3'd3, 1'b1,  8'sd3, 1'b1, 1'b0},
    '{3'd0, 1'b1,  8'sd3, 1'b1, 1'b1},
    '{3'd3, 1'b0,  8'sd5, 1'b0, 1'b1},
    '{3'd2, 1'b0, -8'sd1, 1'b0, 1'b0}
  };

  logic               clk;
  logic               rst_n;
  logic               sync_in;
  logic               reg_wr;
  logic [7:0]         reg_addr;
  logic [7:0]         reg_wdata;
  logic [7:0]         reg_rdata;
  logic               irq_o;
  logic [PHASE_W-1:0] phase_o;

  int checks = 0;
  int errors = 0;
  int adj_a  = 0;
  int adj_b  = 0;
  int gen_left = 0;

  sync_align_ctrl #(.PERIOD(PERIOD), .PHASE_W(PHASE_W)) i_sync_align_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .phase_o   (phase_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference pulse generator: one-cycle pulses, period PERIOD + pending adjust
  initial begin
    sync_in = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (gen_left == 0) begin
        sync_in  = 1'b1;
        gen_left = PERIOD - 1 + adj_a;
        adj_a    = adj_b;
        adj_b    = 0;
      end else begin
        sync_in  = 1'b0;
        gen_left = gen_left - 1;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string row_tag(input int i);
    case (i)
      0: return "R6";
      1: return "R5";
      2: return "R7";
      3: return "R7";
      4: return "R3";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [PHASE_W-1:0] prev;
    int bad;
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = 8'h00;
    reg_wdata = 8'h00;

    // R1 reset state
    wait_cyc(3);
    check("R1 phase", 8'(phase_o), 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rd(8'h10, v); check("R1 ctrl", v, 8'h00);
    rd(8'h11, v); check("R1 irqen", v, 8'h00);
    rd(8'h12, v); check("R1 status", v, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(6);

    // R4 free-running wrap while disabled
    bad = 0;
    @(negedge clk); prev = phase_o;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (phase_o != ((prev == PHASE_W'(PERIOD - 1)) ? '0 : prev + PHASE_W'(1))) bad++;
      prev = phase_o;
    end
    check("R4 wrap count", 8'(bad), 8'h00);

    // table-driven alignment scenarios
    for (int i = 0; i < NROWS; i++) begin
      logic [7:0] ctrl;
      ctrl = {1'b1, 3'b000, ROWS[i].rise, ROWS[i].dep};
      wr(8'h10, 8'h00);
      wr(8'h10, ctrl);
      rd(8'h10, v); check("R2 ctrl readback", v, ctrl);
      wait_cyc(500);
      wr(8'h12, 8'h80);
      rd(8'h12, v); check({row_tag(i), " baseline lock"}, v, 8'h40);
      @(negedge clk);
      adj_a = int'(ROWS[i].shift);
      adj_b = ROWS[i].once ? -int'(ROWS[i].shift) : 0;
      wait_cyc(600);
      rd(8'h12, v); check({row_tag(i), " after disturbance"}, v, {ROWS[i].exp_lost, 1'b1, 6'd0});
    end

    // R8 sticky loss flag and its clear
    @(negedge clk); adj_a = 4;
    wait_cyc(400);
    rd(8'h12, v); check("R8 loss set", v, 8'hC0);
    wr(8'h12, 8'h7F);
    rd(8'h12, v); check("R8 write bit7=0 keeps", v, 8'hC0);
    wr(8'h12, 8'h80);
    rd(8'h12, v); check("R8 write bit7=1 clears", v, 8'h40);

    // R10 interrupt enables
    wr(8'h11, 8'h40);
    rd(8'h11, v); check("R10 irqen readback", v, 8'h40);
    check("R10 irq on lock", {7'd0, irq_o}, 8'h01);
    wr(8'h11, 8'h80);
    rd(8'h12, v);
    check("R10 irq lost-only quiet", {7'd0, irq_o}, 8'h00);
    @(negedge clk); adj_a = 4;
    wait_cyc(400);
    rd(8'h12, v);
    check("R10 irq on loss", {7'd0, irq_o}, 8'h01);
    wr(8'h11, 8'h00);
    rd(8'h12, v);
    check("R10 irq masked", {7'd0, irq_o}, 8'h00);

    // R9 status layout and unmapped addresses
    rd(8'h12, v); check("R9 status layout", v, 8'hC0);
    rd(8'h13, v); check("R9 unmapped 0x13", v, 8'h00);
    rd(8'h00, v); check("R9 unmapped 0x00", v, 8'h00);

    // R11 disabled: no lock, loss flag kept
    wr(8'h10, 8'h02);
    wait_cyc(300);
    rd(8'h12, v); check("R11 disabled status", v, 8'h80);
    @(negedge clk); adj_a = 6;
    wait_cyc(300);
    rd(8'h12, v); check("R11 shift ignored", v, 8'h80);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule